// File: doc/BRIEF.md
# CAN Identifier Acceptance Filter

This block decides whether a received CAN frame should be taken into the receive buffer. It compares the frame's four identifier bytes against the stored code and mask bytes. Those four bytes carry the identifier bits, the extended-format flag and the remote-request flag. The storage is two banks, and each bank holds four code bytes and four mask bytes.

A two-bit mode input decides how that same storage is cut up:

- **Wide mode:** two 32-bit filters.
- **Half mode:** four 16-bit filters, which look at identifier bytes 0 and 1.
- **Quarter mode:** eight 8-bit filters, which look at identifier byte 0 only.
- **Closed mode:** nothing is accepted.

When a frame is presented with a valid strobe, the block evaluates it once. One clock later it reports:

- the per-filter hit flags;
- a one-cycle accept pulse;
- the index of the lowest-numbered filter that hit.

A sticky receive-full flag is set on every accept. It is cleared by a clear input. Code and mask bytes are loaded through a byte-wide write port.

Top module: `can_id_filter`

## Requirements
- R1: After reset all code and mask bytes are 0x00, and `accept`, `hit_vec`, `hit_idx` and `rx_full` are all 0.
- R2: For each filter, an identifier bit matches when its mask bit is 1 (don't-care) or when the identifier bit equals the code bit. A filter hits only when every one of its bits matches.
- R3: With `mode`=00 (wide), filter b (b = bank 0 or 1) compares identifier bytes 0..3 with code/mask bytes 0..3 of bank b. Only `hit_vec[1:0]` can be set.
- R4: With `mode`=01 (half), filter 2b+h compares identifier bytes 0 and 1 with code/mask bytes 2h and 2h+1 of bank b. Only `hit_vec[3:0]` can be set.
- R5: With `mode`=10 (quarter), filter 4b+k compares identifier byte 0 with code/mask byte k of bank b.
- R6: With `mode`=11 (closed), no filter hits, `accept` stays 0, and `rx_full` is not set by the frame.
- R7: The frame is evaluated at the rising edge where `id_valid` is 1. In the following cycle:
  - `accept` is 1 for exactly that cycle, if any filter hit;
  - `hit_vec` holds that frame's hits;
  - `hit_idx` holds the lowest hitting index, or 0 if nothing hit.

  Without `id_valid`, `accept` is 0 and `hit_vec`/`hit_idx` hold their values.
- R8: `rx_full` becomes 1 in the cycle `accept` is 1 and stays 1 until a cycle with `rxf_clr`=1. When an accept and a clear fall on the same edge, the set wins.
- R9: A register write on the same edge as `id_valid` does not affect that frame. It applies from the next frame on.
- R10: Write address map. The identifier bytes come from `id_bytes`, with byte 0 = bits [31:24] and byte 3 = bits [7:0].

  | `cfg_addr` bit | Meaning |
  |---|---|
  | [3] | 0 = code, 1 = mask |
  | [2] | bank |
  | [1:0] | byte index |

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Write enable for a code or mask byte |
| cfg_addr | input | 4 | Write address: mask/code select, bank, byte |
| cfg_wdata | input | 8 | Write data byte |
| mode | input | 2 | Filter granularity: 00 wide, 01 half, 10 quarter, 11 closed |
| id_valid | input | 1 | Identifier bytes valid; the frame is evaluated this edge |
| id_bytes | input | 32 | Identifier bytes 0..3, byte 0 in the top bits |
| rxf_clr | input | 1 | Clears the receive-full flag |
| accept | output | 1 | One-cycle pulse: the last frame was accepted |
| hit_vec | output | 8 | Per-filter hit flags of the last frame |
| hit_idx | output | 3 | Lowest hitting filter index of the last frame |
| rx_full | output | 1 | Sticky receive-full flag |

## Verification
**Quarter mode.** Identifier byte 0 is swept over all 256 values against eight filters that have different codes and mask widths. This shows whether each mask bit is a don't-care, and whether each of the byte filters maps to its own hit index. Overlapping filters show whether the lowest index is the one reported.

**Half mode.** Each byte-0 value is paired with second bytes taken from each filter's code. This separates the two half filters of a bank, and shows when the second byte is the one that decides.

**Wide mode.** The last identifier byte is swept with two banks that differ only in that byte. This checks that all four bytes take part and that the two bank hit bits stay apart.

**Closed mode.** An all-don't-care setting is swept to show that nothing gets through.

**Timing cases.** Directed cycles cover two events landing on one edge: a write coinciding with a frame, and a clear coinciding with an accept.

// File: rtl/can_filt_pkg.sv
package can_filt_pkg;

    // Filter granularity selected by the mode input
    typedef enum logic [1:0] {
        FM_WIDE    = 2'b00,
        FM_HALF    = 2'b01,
        FM_QUARTER = 2'b10,
        FM_CLOSED  = 2'b11
    } filt_mode_e;

    // Code/mask bytes per bank and half-filters per bank
    localparam int BANK_BYTES = 4;
    localparam int BANK_HALVES = 2;

endpackage

// File: rtl/can_filt_regs.sv
module can_filt_regs
    import can_filt_pkg::*;
#(
    parameter int BYTE_W    = 8,
    parameter int NUM_BANKS = 2,
    localparam int NREG     = NUM_BANKS * BANK_BYTES,
    localparam int IDX_W    = $clog2(NREG),
    localparam int ADDR_W   = IDX_W + 1
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        we,
    input  logic [ADDR_W-1:0]           addr,
    input  logic [BYTE_W-1:0]           wdata,
    output logic [NREG-1:0][BYTE_W-1:0] code,
    output logic [NREG-1:0][BYTE_W-1:0] mask
);

    typedef struct packed {
        logic [NREG-1:0][BYTE_W-1:0] code;
        logic [NREG-1:0][BYTE_W-1:0] mask;
    } regs_s;

    regs_s regs_d, regs_q;

    logic            sel_mask;
    logic [IDX_W-1:0] sel_idx;

    assign sel_mask = addr[ADDR_W-1];
    assign sel_idx  = addr[IDX_W-1:0];

    always_comb begin
        regs_d = regs_q;
        if (we) begin
            if (sel_mask) begin
                regs_d.mask[sel_idx] = wdata;
            end else begin
                regs_d.code[sel_idx] = wdata;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign code = regs_q.code;
    assign mask = regs_q.mask;

endmodule

// File: rtl/can_filt_bank.sv
module can_filt_bank
    import can_filt_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic [BANK_BYTES-1:0][BYTE_W-1:0] code,
    input  logic [BANK_BYTES-1:0][BYTE_W-1:0] mask,
    input  logic [BANK_BYTES-1:0][BYTE_W-1:0] id,
    output logic                              hit_wide,
    output logic [BANK_HALVES-1:0]            hit_half,
    output logic [BANK_BYTES-1:0]             hit_quarter
);

    // Per-byte match of identifier byte k against code byte k (wide mode)
    logic [BANK_BYTES-1:0] lane_eq;
    // Match of identifier byte 0 against each code byte (quarter mode)
    logic [BANK_BYTES-1:0] first_eq;
    // Match of identifier byte 1 against each code byte (half mode)
    logic [BANK_BYTES-1:0] second_eq;

    for (genvar k = 0; k < BANK_BYTES; k++) begin : g_byte
        assign lane_eq[k]   = ((id[k] ^ code[k]) & ~mask[k]) == '0;
        assign first_eq[k]  = ((id[0] ^ code[k]) & ~mask[k]) == '0;
        assign second_eq[k] = ((id[1] ^ code[k]) & ~mask[k]) == '0;
    end

    for (genvar h = 0; h < BANK_HALVES; h++) begin : g_half
        assign hit_half[h] = first_eq[2*h] & second_eq[2*h+1];
    end

    assign hit_wide    = &lane_eq;
    assign hit_quarter = first_eq;

endmodule

// File: rtl/can_filt_prio.sv
module can_filt_prio #(
    parameter int NFILT = 8,
    localparam int IDX_W = $clog2(NFILT)
) (
    input  logic [NFILT-1:0] req,
    output logic [IDX_W-1:0] idx
);

    // Lowest set bit wins; zero when no bit is set
    always_comb begin
        idx = '0;
        for (int i = NFILT - 1; i >= 0; i--) begin
            if (req[i]) begin
                idx = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/can_id_filter.sv
module can_id_filter
    import can_filt_pkg::*;
#(
    parameter int BYTE_W    = 8,
    parameter int NUM_BANKS = 2,
    localparam int NREG     = NUM_BANKS * BANK_BYTES,
    localparam int NFILT    = NUM_BANKS * BANK_BYTES,
    localparam int NHALF    = NUM_BANKS * BANK_HALVES,
    localparam int IDX_W    = $clog2(NFILT),
    localparam int ADDR_W   = $clog2(NREG) + 1,
    localparam int ID_W     = BANK_BYTES * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [BYTE_W-1:0] cfg_wdata,
    input  logic [1:0]        mode,
    input  logic              id_valid,
    input  logic [ID_W-1:0]   id_bytes,
    input  logic              rxf_clr,
    output logic              accept,
    output logic [NFILT-1:0]  hit_vec,
    output logic [IDX_W-1:0]  hit_idx,
    output logic              rx_full
);

    typedef struct packed {
        logic             accept;
        logic [NFILT-1:0] hits;
        logic [IDX_W-1:0] idx;
        logic             full;
    } res_s;

    res_s res_d, res_q;

    logic [NREG-1:0][BYTE_W-1:0]       code, mask;
    logic [BANK_BYTES-1:0][BYTE_W-1:0] id_arr;
    logic [NUM_BANKS-1:0]              hit_wide;
    logic [NHALF-1:0]                  hit_half;
    logic [NFILT-1:0]                  hit_quarter;
    logic [NFILT-1:0]                  sel_hits;
    logic [IDX_W-1:0]                  low_idx;
    filt_mode_e                        mode_e;

    assign mode_e = filt_mode_e'(mode);

    // Byte 0 of the identifier sits in the most significant bits
    for (genvar k = 0; k < BANK_BYTES; k++) begin : g_id
        assign id_arr[k] = id_bytes[ID_W-1-k*BYTE_W -: BYTE_W];
    end

    can_filt_regs #(
        .BYTE_W   (BYTE_W),
        .NUM_BANKS(NUM_BANKS)
    ) regs_i (
        .clk  (clk),
        .rst_n(rst_n),
        .we   (cfg_we),
        .addr (cfg_addr),
        .wdata(cfg_wdata),
        .code (code),
        .mask (mask)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        can_filt_bank #(
            .BYTE_W(BYTE_W)
        ) bank_i (
            .code       (code[b*BANK_BYTES +: BANK_BYTES]),
            .mask       (mask[b*BANK_BYTES +: BANK_BYTES]),
            .id         (id_arr),
            .hit_wide   (hit_wide[b]),
            .hit_half   (hit_half[b*BANK_HALVES +: BANK_HALVES]),
            .hit_quarter(hit_quarter[b*BANK_BYTES +: BANK_BYTES])
        );
    end

    // Re-partition bank results into filter indices by mode
    always_comb begin
        sel_hits = '0;
        unique case (mode_e)
            FM_WIDE:    sel_hits[NUM_BANKS-1:0] = hit_wide;
            FM_HALF:    sel_hits[NHALF-1:0]     = hit_half;
            FM_QUARTER: sel_hits                = hit_quarter;
            FM_CLOSED:  sel_hits                = '0;
            default:    sel_hits                = '0;
        endcase
    end

    can_filt_prio #(
        .NFILT(NFILT)
    ) prio_i (
        .req(sel_hits),
        .idx(low_idx)
    );

    always_comb begin
        res_d        = res_q;
        res_d.accept = 1'b0;
        if (id_valid) begin
            res_d.hits   = sel_hits;
            res_d.idx    = low_idx;
            res_d.accept = |sel_hits;
        end
        res_d.full = (res_q.full & ~rxf_clr) | res_d.accept;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_q <= '0;
        end else begin
            res_q <= res_d;
        end
    end

    assign accept  = res_q.accept;
    assign hit_vec = res_q.hits;
    assign hit_idx = res_q.idx;
    assign rx_full = res_q.full;

endmodule

// File: rtl/can_filt_chk.sv
module can_filt_chk #(
    parameter int NFILT     = 8,
    parameter int NUM_BANKS = 2,
    localparam int IDX_W    = $clog2(NFILT)
) (
    input logic             clk,
    input logic             rst_n,
    input logic [1:0]       mode,
    input logic             id_valid,
    input logic             rxf_clr,
    input logic             accept,
    input logic [NFILT-1:0] hit_vec,
    input logic [IDX_W-1:0] hit_idx,
    input logic             rx_full
);

    assert_closed_blocks_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (id_valid && mode == 2'b11) |=> (!accept && hit_vec == '0))
        else $error("closed mode accepted a frame");

    assert_wide_two_filters_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (id_valid && mode == 2'b00) |=> (hit_vec[NFILT-1:NUM_BANKS] == '0))
        else $error("wide mode raised a filter above the bank count");

    assert_half_four_filters_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (id_valid && mode == 2'b01) |=> (hit_vec[NFILT-1:2*NUM_BANKS] == '0))
        else $error("half mode raised a filter above its range");

    assert_no_accept_without_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !id_valid |=> (!accept && $stable(hit_vec) && $stable(hit_idx)))
        else $error("result changed without a frame");

    assert_lowest_index_R7: assert property (@(posedge clk) disable iff (!rst_n)
        accept |-> (hit_vec[hit_idx] &&
                    ((hit_vec & ((NFILT'(1) << hit_idx) - NFILT'(1))) == '0)))
        else $error("reported index is not the lowest hit");

    assert_full_on_accept_R8: assert property (@(posedge clk) disable iff (!rst_n)
        accept |-> rx_full)
        else $error("accept without receive-full");

    assert_full_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rxf_clr && !id_valid) |=> !rx_full)
        else $error("receive-full did not clear");

    assert_full_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!rxf_clr && !id_valid) |=> $stable(rx_full))
        else $error("receive-full changed with no cause");

endmodule

bind can_id_filter can_filt_chk #(
    .NFILT    (NFILT),
    .NUM_BANKS(NUM_BANKS)
) chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .mode    (mode),
    .id_valid(id_valid),
    .rxf_clr (rxf_clr),
    .accept  (accept),
    .hit_vec (hit_vec),
    .hit_idx (hit_idx),
    .rx_full (rx_full)
);

// File: tb/can_id_filter_tb_top.sv
module can_id_filter_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [3:0]  cfg_addr = '0;
    logic [7:0]  cfg_wdata = '0;
    logic [1:0]  mode = 2'b00;
    logic        id_valid = 1'b0;
    logic [31:0] id_bytes = '0;
    logic        rxf_clr = 1'b0;
    logic        accept;
    logic [7:0]  hit_vec;
    logic [2:0]  hit_idx;
    logic        rx_full;

    int errors = 0;
    int checks = 0;
    logic [7:0] sc [8];
    logic [7:0] sm [8];
    logic ex_full = 1'b0;

    always #5 clk = ~clk;

    can_id_filter dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .mode(mode), .id_valid(id_valid),
        .id_bytes(id_bytes), .rxf_clr(rxf_clr), .accept(accept),
        .hit_vec(hit_vec), .hit_idx(hit_idx), .rx_full(rx_full)
    );

    function automatic logic mt(logic [7:0] a, logic [7:0] c, logic [7:0] m);
        return ((a ^ c) & ~m) == 8'h00;
    endfunction

    function automatic logic [7:0] exp_hits(logic [1:0] m, logic [31:0] id);
        logic [7:0] ib [4];
        logic [7:0] h = '0;
        for (int k = 0; k < 4; k++) ib[k] = id[31-8*k -: 8];
        case (m)
            2'b00: for (int b = 0; b < 2; b++)
                       h[b] = mt(ib[0], sc[4*b], sm[4*b]) && mt(ib[1], sc[4*b+1], sm[4*b+1]) &&
                              mt(ib[2], sc[4*b+2], sm[4*b+2]) && mt(ib[3], sc[4*b+3], sm[4*b+3]);
            2'b01: for (int b = 0; b < 2; b++)
                       for (int f = 0; f < 2; f++)
                           h[2*b+f] = mt(ib[0], sc[4*b+2*f], sm[4*b+2*f]) &&
                                      mt(ib[1], sc[4*b+2*f+1], sm[4*b+2*f+1]);
            2'b10: for (int j = 0; j < 8; j++) h[j] = mt(ib[0], sc[j], sm[j]);
            default: h = '0;
        endcase
        return h;
    endfunction

    function automatic logic [2:0] low_of(logic [7:0] v);
        for (int i = 0; i < 8; i++) if (v[i]) return 3'(i);
        return 3'd0;
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // R10: addr[3] mask, addr[2] bank, addr[1:0] byte
    task automatic wr(logic is_mask, int idx, logic [7:0] d);
        @(negedge clk);
        cfg_we = 1'b1;
        cfg_addr = {is_mask, 3'(idx)};
        cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
        if (is_mask) sm[idx] = d; else sc[idx] = d;
    endtask

    logic [7:0] last_hits = '0;
    logic [2:0] last_idx = '0;

    task automatic eval(logic [1:0] m, logic [31:0] id, string req);
        logic [7:0] eh;
        @(negedge clk);
        mode = m;
        id_bytes = id;
        id_valid = 1'b1;
        eh = exp_hits(m, id);
        @(negedge clk);
        id_valid = 1'b0;
        ex_full = ex_full | (|eh);
        last_hits = eh;
        last_idx = low_of(eh);
        check(req, {7'd0, accept, hit_vec, 5'd0, hit_idx, 7'd0, rx_full},
                   {7'd0, |eh, eh, 5'd0, low_of(eh), 7'd0, ex_full});
    endtask

    task automatic clear_full();
        @(negedge clk);
        rxf_clr = 1'b1;
        @(negedge clk);
        rxf_clr = 1'b0;
        ex_full = 1'b0;
        check("R8 clear", {31'd0, rx_full}, 32'd0);
    endtask

    initial begin
        for (int i = 0; i < 8; i++) begin
            sc[i] = 8'h00;
            sm[i] = 8'h00;
        end
        repeat (3) @(negedge clk);
        check("R1 reset", {20'd0, accept, hit_vec, hit_idx}, 32'd0);
        check("R1 reset full", {31'd0, rx_full}, 32'd0);
        rst_n = 1'b1;

        // R1: reset registers are zero, so id 0 hits wide filters 0 and 1
        eval(2'b00, 32'h0000_0000, "R1 R3 reset regs");
        eval(2'b00, 32'h0000_0001, "R1 R3 reset regs miss");
        clear_full();

        // R5 / R2: quarter-mode sweep of byte 0
        for (int j = 0; j < 8; j++) wr(1'b0, j, 8'(j * 8'h25 + 8'h13));
        wr(1'b1, 0, 8'h00); wr(1'b1, 1, 8'h01); wr(1'b1, 2, 8'h03); wr(1'b1, 3, 8'h0F);
        wr(1'b1, 4, 8'h80); wr(1'b1, 5, 8'hF0); wr(1'b1, 6, 8'h3C); wr(1'b1, 7, 8'hFE);
        for (int v = 0; v < 256; v++) eval(2'b10, {8'(v), 8'(v * 7), 16'hA5C3}, "R5 R2 quarter sweep");

        // R7: no frame, outputs hold and accept stays low
        @(negedge clk);
        @(negedge clk);
        check("R7 hold", {20'd0, accept, hit_vec, hit_idx}, {20'd0, 1'b0, last_hits, last_idx});
        clear_full();

        // R4: half-mode sweep, second byte taken from each filter's code
        for (int v = 0; v < 256; v++)
            for (int s = 0; s < 4; s++)
                eval(2'b01, {8'(v), sc[2*s+1] ^ 8'(s == 3 ? 1 : 0), 16'h0}, "R4 R2 half sweep");
        clear_full();

        // R3: wide mode, banks differ only in byte 3
        wr(1'b0, 0, 8'h12); wr(1'b0, 1, 8'h34); wr(1'b0, 2, 8'h56); wr(1'b0, 3, 8'h78);
        wr(1'b0, 4, 8'h12); wr(1'b0, 5, 8'h34); wr(1'b0, 6, 8'h56); wr(1'b0, 7, 8'h7A);
        for (int j = 0; j < 8; j++) wr(1'b1, j, 8'h00);
        wr(1'b1, 7, 8'h0F);
        for (int v = 0; v < 256; v++) eval(2'b00, {24'h123456, 8'(v)}, "R3 wide sweep");
        eval(2'b00, 32'h1334_5678, "R3 wide byte0 miss");
        clear_full();

        // R6: closed mode with every bit don't-care
        for (int j = 0; j < 8; j++) wr(1'b1, j, 8'hFF);
        for (int v = 0; v < 256; v++) eval(2'b11, {8'(v), 8'(~v), 16'(v * 3)}, "R6 closed sweep");
        check("R6 full not set", {31'd0, rx_full}, 32'd0);

        // R9: write coinciding with a frame applies only to the next frame
        for (int j = 0; j < 8; j++) wr(1'b1, j, 8'h00);
        for (int j = 0; j < 8; j++) wr(1'b0, j, 8'hC0);
        @(negedge clk);
        mode = 2'b10; id_bytes = 32'h5500_0000; id_valid = 1'b1;
        cfg_we = 1'b1; cfg_addr = 4'h2; cfg_wdata = 8'h55;
        @(negedge clk);
        id_valid = 1'b0; cfg_we = 1'b0;
        check("R9 same-edge write ignored", {23'd0, accept, hit_vec}, 32'd0);
        sc[2] = 8'h55;
        eval(2'b10, 32'h5500_0000, "R9 write seen next frame");

        // R8: clear on the same edge as an accept, set wins
        @(negedge clk);
        mode = 2'b10; id_bytes = 32'h5500_0000; id_valid = 1'b1; rxf_clr = 1'b1;
        @(negedge clk);
        id_valid = 1'b0; rxf_clr = 1'b0;
        check("R8 set wins over clear", {30'd0, accept, rx_full}, 32'd3);
        ex_full = 1'b1;
        eval(2'b10, 32'h1100_0000, "R8 sticky on miss");
        clear_full();

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule